// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with Event Status Codes

This block is the receive-only slave side of a two-wire serial bus controller. It oversamples the clock and data lines on the system clock, finds START, repeated START and STOP conditions, and compares each address byte with a programmable 7-bit device address. It can also match the all-zero general call address when that is enabled. Once selected for a write, it takes in any number of data bytes, MSB first, and acknowledges or refuses each one.

Every bus event that software must handle produces a fixed 8-bit status code and raises a pending-event flag. While the flag is up, the block pulls the clock line low, so the bus master waits until software has read the status and the received byte. Software then writes a one to the flag-clear input. A single acknowledge-enable input has two jobs. It decides the ACK or NACK for the next data byte, and it turns recognition of the device's own address on and off. Both pins are open drain: each output is a pull-low enable and never drives a high level.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset the status reads 0xF8, the event flag is 0 and neither line is pulled low.
- R2: An address byte whose upper seven bits equal `own_cfg[7:1]` and whose bit 0 is 0 (write) is ACKed while `ack_en` is 1. SDA is pulled low only while SCL is low, for the ninth clock. Status then becomes 0x60 and the flag is raised.
- R3: The address byte 0x00 is ACKed with status 0x70 only when `own_cfg[0]` is 1. With `own_cfg[0]` at 0 it gets a NACK and raises no flag.
- R4: An address that does not match, or the own address with bit 0 set to 1 (read), is NACKed and raises no flag. Data bytes that follow before the next START are neither ACKed nor reported.
- R5: A data byte ACKed after own-address selection gives status 0x80, and one ACKed after a general call gives 0x90. The byte is then readable on `rx_data`.
- R6: A data byte received while `ack_en` is 0 is NACKed (SDA released on the ninth clock). The status is 0x88 after own-address selection or 0x98 after a general call, and the block returns to the unaddressed state. Later bytes and a STOP produce no event.
- R7: While `ack_en` is 0 the own address is NACKed with no flag. Setting `ack_en` again restores recognition at the next address phase.
- R8: A STOP or a repeated START seen while the block is addressed gives status 0xA0. After a repeated START the next byte is treated as an address.
- R9: From the moment the flag is set, SCL is held low. The flag and the hold stay until `flag_clr` is pulsed, and the clear releases SCL.
- R10: Whenever no event is pending, the status reads 0xF8.
- R11: If a new event and a `flag_clr` pulse arrive in the same cycle, the event wins: the flag stays set with the new status.
- R12: Bits are sampled on SCL rising edges, first bit as the MSB of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_drive_low | output | 1 | Pull-low enable for the clock line (clock stretching) |
| sda_drive_low | output | 1 | Pull-low enable for the data line (acknowledge) |
| own_cfg | input | 8 | Bits 7:1 device address, bit 0 general call enable |
| ack_en | input | 1 | Acknowledge enable and address recognition enable |
| flag_clr | input | 1 | Write-one pulse that clears the pending event |
| event_flag | output | 1 | Event pending; software must service it |
| status | output | 8 | Status code of the pending event, 0xF8 when none |
| rx_data | output | 8 | Last received data byte |

## Verification
The event-raising logic and the software clear can act in the same cycle. This happens when a clear pulse is written at the exact cycle a STOP is recognised on an addressed transfer. The bench creates this case by raising SDA while SCL is high and counting the two synchroniser stages and the detection stage. It then places `flag_clr` on the edge that loads the flag. The result is judged at the ports: the flag must still be high and the status must read 0xA0, which shows that setting takes priority over clearing.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,      // not addressed, watching for START
    ST_ADDR,      // shifting address byte
    ST_ADDR_ACK,  // driving ACK for matched address
    ST_DATA,      // shifting data byte while addressed
    ST_DATA_ACK   // ninth clock of a data byte
  } rx_state_e;

  localparam logic [7:0] SC_OWN_W     = 8'h60;
  localparam logic [7:0] SC_GCALL     = 8'h70;
  localparam logic [7:0] SC_OWN_DACK  = 8'h80;
  localparam logic [7:0] SC_OWN_DNACK = 8'h88;
  localparam logic [7:0] SC_GC_DACK   = 8'h90;
  localparam logic [7:0] SC_GC_DNACK  = 8'h98;
  localparam logic [7:0] SC_STOP_RS   = 8'hA0;
  localparam logic [7:0] SC_NONE      = 8'hF8;

endpackage

// File: rtl/i2c_rx_linemon.sv
module i2c_rx_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic                   scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb begin
        scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_in};
        sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_in};
      end
    end else begin : g_single
      always_comb begin
        scl_pipe_d = scl_in;
        sda_pipe_d = sda_in;
      end
    end
  endgenerate

  // Idle bus lines are high, so all stages reset to one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[SYNC_STAGES-1];
      sda_prev_q <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_pipe_q[SYNC_STAGES-1];
    sda_s     = sda_pipe_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              latch_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] shreg,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] shreg_d, data_d;

  always_comb begin
    shreg_d = shreg;
    data_d  = data_q;
    if (shift_en) shreg_d = {shreg[DATA_W-2:0], bit_in};
    if (latch_en) data_d  = {shreg[DATA_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      data_q <= '0;
    end else begin
      if (shift_en) shreg  <= shreg_d;
      if (latch_en) data_q <= data_d;
    end
  end

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_slave_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] own_cfg,
  input  logic              ack_en,
  output logic              shift_en,
  output logic              latch_en,
  output logic              sda_low,
  output logic              ev_set,
  output logic [7:0]        ev_code,
  output logic              addressed
);

  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(DATA_W - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gc_q, gc_d;
  logic             ackq_q, ackq_d;
  logic             sda_q, sda_d;
  logic             own_hit, gc_hit;

  always_comb begin
    own_hit = ack_en & (rx_byte[DATA_W-1:1] == own_cfg[DATA_W-1:1]) & ~rx_byte[0];
    gc_hit  = ack_en & own_cfg[0] & (rx_byte == '0);
    addressed = (state_q == ST_DATA) | ((state_q == ST_DATA_ACK) & ackq_q);
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    gc_d     = gc_q;
    ackq_d   = ackq_q;
    sda_d    = sda_q;
    shift_en = 1'b0;
    latch_en = 1'b0;
    ev_set   = 1'b0;
    ev_code  = SC_NONE;
    if (start_det) begin
      if (addressed) begin
        ev_set  = 1'b1;
        ev_code = SC_STOP_RS;
      end
      state_d = ST_ADDR;
      cnt_d   = '0;
      sda_d   = 1'b0;
    end else if (stop_det) begin
      if (addressed) begin
        ev_set  = 1'b1;
        ev_code = SC_STOP_RS;
      end
      state_d = ST_IDLE;
      cnt_d   = '0;
      sda_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            shift_en = 1'b1;
            cnt_d    = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (own_hit || gc_hit) begin
              sda_d   = 1'b1;
              gc_d    = gc_hit & ~own_hit;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_rise) begin
            cnt_d = ACK_BIT;
          end else if (scl_fall && cnt_q == ACK_BIT) begin
            sda_d   = 1'b0;
            ev_set  = 1'b1;
            ev_code = gc_q ? SC_GCALL : SC_OWN_W;
            state_d = ST_DATA;
            cnt_d   = '0;
          end
        end
        ST_DATA: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            shift_en = 1'b1;
            latch_en = (cnt_q == PRE_LAST);
            cnt_d    = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            ackq_d  = ack_en;
            sda_d   = ack_en;
            state_d = ST_DATA_ACK;
          end
        end
        ST_DATA_ACK: begin
          if (scl_rise) begin
            cnt_d = ACK_BIT;
          end else if (scl_fall && cnt_q == ACK_BIT) begin
            sda_d   = 1'b0;
            ev_set  = 1'b1;
            ev_code = gc_q ? (ackq_q ? SC_GC_DACK  : SC_GC_DNACK)
                           : (ackq_q ? SC_OWN_DACK : SC_OWN_DNACK);
            state_d = ackq_q ? ST_DATA : ST_IDLE;
            cnt_d   = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gc_q    <= 1'b0;
      ackq_q  <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gc_q    <= gc_d;
      ackq_q  <= ackq_d;
      sda_q   <= sda_d;
    end
  end

  assign sda_low = sda_q;

  AST_ACK_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_q) |-> !scl_s); // R2

  AST_NACK_UNADDRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set && (ev_code == SC_OWN_DNACK || ev_code == SC_GC_DNACK)) |=> (state_q == ST_IDLE)); // R6

  AST_ADDR_FIELD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> (sda_q && (ADDR_W == DATA_W - 1))); // R2

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_slave_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [DATA_W-1:0] own_cfg,
  input  logic              ack_en,
  input  logic              flag_clr,
  output logic              event_flag,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] rx_data
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              shift_en, latch_en, sda_low, ev_set, addressed;
  logic [7:0]        ev_code;
  logic [DATA_W-1:0] shreg;
  logic              flag_q, flag_d;
  logic [7:0]        status_q, status_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_rx_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (shift_en),
    .latch_en (latch_en),
    .bit_in   (sda_s),
    .shreg    (shreg),
    .data_q   (rx_data)
  );

  i2c_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rx_byte   (shreg),
    .own_cfg   (own_cfg),
    .ack_en    (ack_en),
    .shift_en  (shift_en),
    .latch_en  (latch_en),
    .sda_low   (sda_low),
    .ev_set    (ev_set),
    .ev_code   (ev_code),
    .addressed (addressed)
  );

  // Event flag and status: a new event outranks a clear in the same cycle.
  always_comb begin
    flag_d   = flag_q;
    status_d = status_q;
    if (ev_set) begin
      flag_d   = 1'b1;
      status_d = ev_code;
    end else if (flag_clr && flag_q) begin
      flag_d   = 1'b0;
      status_d = SC_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q   <= 1'b0;
      status_q <= SC_NONE;
    end else begin
      flag_q   <= flag_d;
      status_q <= status_d;
    end
  end

  assign event_flag    = flag_q;
  assign status        = status_q;
  assign scl_drive_low = flag_q;
  assign sda_drive_low = sda_low;

  AST_STATUS_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_q == (status_q != SC_NONE)); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_set && flag_clr) |=> (flag_q && status_q != SC_NONE)); // R11

  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_q && !flag_clr) |=> (flag_q && scl_drive_low)); // R9

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_q && flag_clr && !ev_set) |=> !scl_drive_low); // R9

endmodule

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;

  logic       clk, rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_line, sda_line;
  logic       scl_drive_low, sda_drive_low;
  logic [7:0] own_cfg;
  logic       ack_en, flag_clr;
  logic       event_flag;
  logic [7:0] status, rx_data;

  int n_run, n_fail;
  bit done;
  localparam int Q = 10;

  assign scl_line = ~(m_scl_low | scl_drive_low);
  assign sda_line = ~(m_sda_low | sda_drive_low);

  i2c_slave_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_line),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .own_cfg       (own_cfg),
    .ack_en        (ack_en),
    .flag_clr      (flag_clr),
    .event_flag    (event_flag),
    .status        (status),
    .rx_data       (rx_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start;
    wcyc(Q); m_sda_low = 1'b1; wcyc(Q); m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic bus_rstart;
    m_sda_low = 1'b0; wcyc(Q); m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b1; wcyc(Q); m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; wcyc(Q); m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b0; wcyc(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda_low = ~b; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    s = sda_line; wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
    wcyc(6);
  endtask

  task automatic clear_flag;
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    wcyc(2);
  endtask

  task automatic t_reset;
    chk("R1 status after reset", status, 8'hF8);
    chk("R1 flag after reset", {7'd0, event_flag}, 8'h00);
    chk("R1 line drives after reset", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);
  endtask

  task automatic t_own_write;
    logic a;
    own_cfg = 8'hA4; ack_en = 1'b1;
    bus_start();
    send_byte(8'hA4, a);
    chk("R2 own address ACK", {7'd0, a}, 8'h01);
    chk("R2 status own write", status, 8'h60);
    chk("R9 SCL held at event", {7'd0, scl_drive_low}, 8'h01);
    wcyc(40);
    chk("R9 SCL still held", {6'd0, event_flag, scl_drive_low}, 8'h03);
    clear_flag();
    chk("R9 SCL released by clear", {6'd0, event_flag, scl_drive_low}, 8'h00);
    chk("R10 status idle after clear", status, 8'hF8);
    send_byte(8'h2D, a);
    chk("R5 data ACK", {7'd0, a}, 8'h01);
    chk("R5 status own data ack", status, 8'h80);
    chk("R12 MSB first byte", rx_data, 8'h2D);
    clear_flag();
    bus_stop(); wcyc(6);
    chk("R8 STOP while addressed", status, 8'hA0);
    clear_flag();
  endtask

  task automatic t_gcall;
    logic a;
    own_cfg = 8'hA5; ack_en = 1'b1;
    bus_start();
    send_byte(8'h00, a);
    chk("R3 general call ACK", {7'd0, a}, 8'h01);
    chk("R3 status general call", status, 8'h70);
    clear_flag();
    send_byte(8'h5E, a);
    chk("R5 status gc data ack", status, 8'h90);
    chk("R5 gc data byte", rx_data, 8'h5E);
    ack_en = 1'b0;
    clear_flag();
    send_byte(8'h11, a);
    chk("R6 gc data NACK", {7'd0, a}, 8'h00);
    chk("R6 status gc data nack", status, 8'h98);
    chk("R6 data kept on nack", rx_data, 8'h11);
    clear_flag();
    ack_en = 1'b1;
    send_byte(8'h22, a);
    chk("R6 no ACK after nack", {7'd0, a}, 8'h00);
    chk("R6 no event after nack", {7'd0, event_flag}, 8'h00);
    bus_stop(); wcyc(6);
    chk("R6 no STOP event when unaddressed", status, 8'hF8);
  endtask

  task automatic t_gcall_off;
    logic a;
    own_cfg = 8'hA4; ack_en = 1'b1;
    bus_start();
    send_byte(8'h00, a);
    chk("R3 gc disabled NACK", {7'd0, a}, 8'h00);
    chk("R3 gc disabled no event", {7'd0, event_flag}, 8'h00);
    send_byte(8'h33, a);
    chk("R4 following byte ignored", {6'd0, a, event_flag}, 8'h00);
    bus_stop(); wcyc(6);
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start();
    send_byte(8'hA6, a);
    chk("R4 wrong address NACK", {6'd0, a, event_flag}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'hA5, a);
    chk("R4 read direction NACK", {6'd0, a, event_flag}, 8'h00);
    send_byte(8'h44, a);
    chk("R4 status unchanged", status, 8'hF8);
    bus_stop(); wcyc(6);
  endtask

  task automatic t_ack_gate;
    logic a;
    ack_en = 1'b0;
    bus_start();
    send_byte(8'hA4, a);
    chk("R7 address NACK while disabled", {6'd0, a, event_flag}, 8'h00);
    bus_stop();
    ack_en = 1'b1;
    bus_start();
    send_byte(8'hA4, a);
    chk("R7 recognition resumes", status, 8'h60);
    ack_en = 1'b0;
    clear_flag();
    send_byte(8'h96, a);
    chk("R6 own data NACK", {7'd0, a}, 8'h00);
    chk("R6 status own data nack", status, 8'h88);
    clear_flag();
    ack_en = 1'b1;
    bus_stop(); wcyc(6);
    chk("R6 STOP after nack silent", {7'd0, event_flag}, 8'h00);
  endtask

  task automatic t_rstart;
    logic a;
    bus_start();
    send_byte(8'hA4, a); clear_flag();
    send_byte(8'h7E, a);
    chk("R5 data before rstart", status, 8'h80);
    clear_flag();
    bus_rstart(); wcyc(2);
    chk("R8 repeated START while addressed", status, 8'hA0);
    clear_flag();
    send_byte(8'hA4, a);
    chk("R8 address after repeated START", status, 8'h60);
    clear_flag();
    bus_stop(); wcyc(6);
    chk("R8 STOP after readdress", status, 8'hA0);
    clear_flag();
  endtask

  task automatic t_collide;
    logic a;
    bus_start();
    send_byte(8'hA4, a); clear_flag();
    send_byte(8'h3C, a); clear_flag();
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R11 event beats clear flag", {7'd0, event_flag}, 8'h01);
    chk("R11 event beats clear status", status, 8'hA0);
    clear_flag();
    chk("R10 idle after collision clear", status, 8'hF8);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
    own_cfg = 8'hA4; ack_en = 1'b1; flag_clr = 1'b0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_own_write();
    t_gcall();
    t_gcall_off();
    t_mismatch();
    t_ack_gate();
    t_rstart();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R9 watchdog: actual stalled, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule